// File: doc/BRIEF.md
# Bridge Control Register File

A bank of 32-bit control and status words for a host bridge. Software reaches it with full-word accesses only: the byte address is given, its two low bits are ignored, and the word index is the byte address divided by four. Most words are plain read/write storage with fixed reset defaults. The interrupt-enable word cannot be written directly. It changes only through a set port, which ORs bits in, and a clear port, which removes them. The general configuration word also issues a one-cycle system reset request when software turns its self-reset bit on.

Accesses use plain strobes and complete in a single cycle with no back-pressure. A write commits at the clock edge. Read data is combinational from the addressed word while the read strobe is high. No valid/ready handshake is involved, because no data stream passes through the block.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset these words read as follows: index 0 = 0x00000C40, index 1 = 0x00001384 (bits 2, 7, 8, 9 and 12 set), index 2 = 0x2BFF8010, index 3 = 0x255E0091, index 4 = 0x00006140, index 7 = 0x000001FF, index 8 = 0x000001FF, index 26 = 0x00000008, index 27 = 0x10000000. Every other index, including the enable word, reads 0.
- R2: The word index is `addr[6:2]`, and `addr[1:0]` has no effect. A write to any index in 0..13 or 16..27 stores `wr_data`, and a later read of that index returns it.
- R3: A write to index 12 stores the value at index 12 and ORs it into the enable word at index 14.
- R4: A write to index 13 stores the value at index 13 and clears, in the enable word, every bit set in the value.
- R5: Writes to index 14 (enable) and index 15 (interrupt status) change nothing. Index 15 always reads 0.
- R6: A write to index 1 whose bit 2 is 1 while the stored bit 2 is 0 raises `reset_req` for exactly one cycle, starting after the write's clock edge. A write to index 1 while the stored bit 2 is already 1 raises no request. The written value is stored in both cases.
- R7: Indices 28..31 discard writes and read as 0.
- R8: `rd_data` is 0 while `rd_en` is low. A read in the same cycle as a write to the same index returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Byte address of the accessed word |
| wr_en | input | 1 | Write strobe, one full word per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data of the addressed word, 0 when not reading |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the enable word on every cycle. A set write must leave all of its bits on, a clear write must leave all of its bits off, and without either the word must hold still. They also check that a reset request is never longer than one cycle and always follows a write to the configuration word. The bench scenarios cover the reset defaults, the 0-to-1 condition on the self-reset bit, the discarding of writes to read-only and unused indices, and the read-before-write ordering within a cycle.

// File: rtl/bridge_ctl_pkg.sv
package bridge_ctl_pkg;
  localparam int NUM_REGS     = 28;
  localparam int IDX_PWRON    = 0;
  localparam int IDX_GENCFG   = 1;
  localparam int IDX_IODEV    = 2;
  localparam int IDX_SDRAM    = 3;
  localparam int IDX_ADDRMAP  = 4;
  localparam int IDX_GPIO_DAT = 7;
  localparam int IDX_GPIO_OE  = 8;
  localparam int IDX_EN_SET   = 12;
  localparam int IDX_EN_CLR   = 13;
  localparam int IDX_EN       = 14;
  localparam int IDX_STATUS   = 15;
  localparam int IDX_DQ       = 26;
  localparam int IDX_MEMSZ    = 27;
  localparam int SELF_RST_BIT = 2;

  function automatic logic [31:0] reset_value(input int idx);
    case (idx)
      IDX_PWRON:    return 32'h0000_0C40;
      IDX_GENCFG:   return 32'h0000_1384;
      IDX_IODEV:    return 32'h2BFF_8010;
      IDX_SDRAM:    return 32'h255E_0091;
      IDX_ADDRMAP:  return 32'h0000_6140;
      IDX_GPIO_DAT: return 32'h0000_01FF;
      IDX_GPIO_OE:  return 32'h0000_01FF;
      IDX_DQ:       return 32'h0000_0008;
      IDX_MEMSZ:    return 32'h1000_0000;
      default:      return 32'h0;
    endcase
  endfunction

  function automatic bit is_plain(input int idx);
    return (idx != IDX_EN) && (idx != IDX_STATUS);
  endfunction
endpackage

// File: rtl/ctl_plain_bank.sv
module ctl_plain_bank
  import bridge_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N      = NUM_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q [N]
);
  for (genvar i = 0; i < N; i++) begin : g_word
    if (is_plain(i)) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q[i] <= DATA_W'(reset_value(i));
        else if (wr_sel[i]) q[i] <= wr_data;
      end
    end else begin : g_ro
      assign q[i] = '0;
    end
  end
endmodule

// File: rtl/ctl_irq_enable.sv
module ctl_irq_enable #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (set_we) en <= en | wr_data;
    else if (clr_we) en <= en & ~wr_data;
  end

  assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en & $past(wr_data)) == $past(wr_data)));
  assert_clr_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en & $past(wr_data)) == '0));
  assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en));
endmodule

// File: rtl/ctl_reset_pulse.sv
module ctl_reset_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic old_bit,
  input  logic new_bit,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= cfg_we && !old_bit && new_bit;
  end

  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  assert_after_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(cfg_we));
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
  import bridge_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [1:0]        unused_lsb;
  logic [NUM_REGS-1:0] wr_sel;
  logic [DATA_W-1:0] bank_q [NUM_REGS];
  logic [DATA_W-1:0] en_q;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign wr_sel[i] = wr_en && (idx == IDX_W'(i));
  end

  ctl_plain_bank #(.DATA_W(DATA_W), .N(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data), .q(bank_q)
  );

  ctl_irq_enable #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_sel[IDX_EN_SET]), .clr_we(wr_sel[IDX_EN_CLR]),
    .wr_data(wr_data), .en(en_q)
  );

  ctl_reset_pulse u_rst (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(wr_sel[IDX_GENCFG]),
    .old_bit(bank_q[IDX_GENCFG][SELF_RST_BIT]),
    .new_bit(wr_data[SELF_RST_BIT]),
    .req(reset_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en && (int'(idx) < NUM_REGS)) begin
      if (int'(idx) == IDX_EN) rd_data = en_q;
      else                     rd_data = bank_q[idx];
    end
  end
endmodule

// File: tb/sim_bridge_ctl_regs.sv
`timescale 1ns/1ps
module sim_bridge_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        reset_req;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] m [32];
  logic [31:0] m_en;

  always #4 clk = ~clk;

  bridge_ctl_regs u0 (.*);

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'h0000_0C40;  1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;  3: return 32'h255E_0091;
      4: return 32'h0000_6140;  7: return 32'h0000_01FF;
      8: return 32'h0000_01FF; 26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expect_rd(input int i);
    if (i == 14) return m_en;
    if (i == 15 || i >= 28) return 32'h0;
    return m[i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d, input string req);
    int i = int'(a[6:2]);
    logic pulse = 1'b0;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    if (i == 1) pulse = !m[1][2] && d[2];
    if (i < 28 && i != 14 && i != 15) m[i] = d;
    if (i == 12) m_en = m_en | d;
    if (i == 13) m_en = m_en & ~d;
    @(negedge clk);
    wr_en = 1'b0;
    if (i == 1) check({req, " R6 pulse"}, {31'b0, reset_req}, {31'b0, pulse});
  endtask

  task automatic do_read(input logic [6:0] a, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    check(req, rd_data, expect_rd(int'(a[6:2])));
    check({req, " R6 no lingering request"}, {31'b0, reset_req}, 32'h0);
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 32; i++) m[i] = dflt(i);
    m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset defaults
    for (int i = 0; i < 32; i++) do_read(7'(i * 4), "R1 default");
    // R8 idle read
    @(negedge clk); #1 check("R8 rd_en low", rd_data, 32'h0);

    // R2 plain write with odd low bits
    do_write(7'(5 * 4 + 3), 32'hDEAD_BEEF, "R2");
    do_read(7'(5 * 4 + 1), "R2 readback low bits ignored");
    // R3 / R4
    do_write(7'(12 * 4), 32'h0000_00F0, "R3");
    do_read(7'(14 * 4), "R3 enable after set");
    do_read(7'(12 * 4), "R3 set word stored");
    do_write(7'(13 * 4), 32'h0000_0030, "R4");
    do_read(7'(14 * 4), "R4 enable after clear");
    do_read(7'(13 * 4), "R4 clear word stored");
    // R5 read-only
    do_write(7'(14 * 4), 32'hFFFF_FFFF, "R5");
    do_read(7'(14 * 4), "R5 enable unchanged");
    do_write(7'(15 * 4), 32'h1234_5678, "R5");
    do_read(7'(15 * 4), "R5 status reads zero");
    // R6: bit 2 already set after reset -> no pulse
    do_write(7'(4), 32'h0000_1384, "R6 already set");
    do_write(7'(4), 32'h0000_0000, "R6 clear bit");
    do_write(7'(4), 32'h0000_0004, "R6 rising");
    do_read(7'(4), "R6 value stored");
    // R7 unused indices
    do_write(7'(29 * 4), 32'hAAAA_5555, "R7");
    do_read(7'(29 * 4), "R7 discard");
    // R8 read during write returns old value
    @(negedge clk);
    addr = 7'(20 * 4); wr_data = 32'h0BAD_F00D; wr_en = 1'b1; rd_en = 1'b1;
    #1 check("R8 read before write", rd_data, m[20]);
    m[20] = 32'h0BAD_F00D;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    do_read(7'(20 * 4), "R8 write landed");

    // random mix R2 R3 R4 R6
    for (int k = 0; k < 400; k++) begin
      logic [6:0]  a = 7'($urandom_range(0, 127));
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 3) == 0) a = 7'({$urandom_range(12, 14), 2'b00});
      if ($urandom_range(0, 1) == 1) do_write(a, d, "R2 random");
      else                           do_read(a, "R2 random read");
    end
    for (int i = 0; i < 32; i++) do_read(7'(i * 4), "R2 final sweep");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule